// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sits beside the CPU core of a small 8-bit microcontroller and decides which clocks run. Software picks a slow divider and whether the oscillator may keep running while halted by writing a control word. The core then asks for a low-power state with a single-cycle wait-for-interrupt or halt strobe. From these inputs the sequencer chooses one of six operating states: run, slow, wait, slow-wait, active-halt and halt. It drives separate enables for the CPU clock, the peripheral clock and the oscillator, and a one-cycle CPU clock-enable strobe that carries the slow divider.

When a low-power state is entered, the block requests that the 2-bit interrupt mask be forced open. Each state has its own set of wake sources. After a full halt, the CPU clock is held off for an oscillator start-up interval before the core resumes. The block also handles a halt request that arrives while the watchdog is running. Depending on an option input, that request either becomes a watchdog reset or freezes the watchdog after one last decrement.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (run), all three clock enables are 1, every pulse output is 0 and `cpu_tick` is high on every cycle.
- R2: A control write with slow=1 and divider select d shows `mode`=1 on the next cycle, and `cpu_tick` then pulses once every 2^(d+1) cycles (2, 4, 8, 16). With slow=0 it pulses every cycle.
- R3: A divider change takes effect only at a prescaler wrap. The gap between consecutive `cpu_tick` pulses is therefore always either the old ratio or the new ratio, never shorter.
- R4: `wfi_req` in run or slow gives, on the next cycle, `mode`=2 (from run) or 3 (from slow), `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1. It also gives a one-cycle `imask_load` with `imask_val`=2'b10. `imask_val` is 2'b00 whenever `imask_load` is low.
- R5: `halt_req` with the oscillator-interrupt-enable control bit set gives, on the next cycle, `mode`=4, the CPU and peripheral enables at 0, `osc_en` at 1, and the `imask_load` pulse.
- R6: `halt_req` with that bit clear gives, on the next cycle, `mode`=5 with all three enables at 0, and the `imask_load` pulse.
- R7: In wait or slow-wait, any `irq_any` returns the block on the next cycle to `mode` 0 or 1. The CPU enable is back at 1 and a one-cycle `wake` pulse is given, with no extra delay.
- R8: Active-halt is left on the next cycle, with a `wake` pulse, only on `irq_rtc`, `irq_css` or `irq_halt_exit`. `irq_any` alone leaves it in `mode`=4.
- R9: Halt is left only on `irq_halt_exit`. The next cycle shows `mode`=6 (start-up) with `osc_en`=1 and `cpu_clk_en`=0. `cpu_clk_en` and `wake` rise exactly 256 cycles after the wake edge, or 4096 cycles if `opt_long_start` was 1 at that edge. `irq_any` and `irq_rtc` leave halt unchanged.
- R10: `halt_req` with the oscillator-interrupt-enable bit clear, `wdg_active`=1 and `opt_halt_rst`=1 does not enter halt. It gives a one-cycle `wdg_rst_req` on the next cycle, and the block stays in run.
- R11: `halt_req` with `wdg_active`=1 and `opt_halt_rst`=0 enters halt and gives a one-cycle `wdg_last_dec`. `wdg_freeze` is 1 from entry until the cycle in which halt is left.
- R12: Entering active-halt with `wdg_active`=1 produces neither `wdg_rst_req`, `wdg_last_dec` nor `wdg_freeze`, whatever `opt_halt_rst` is.
- R13: Asserting `rst_n` in any state returns the block at once to run, with slow, divider and watchdog freeze cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Loads the control word below |
| ctl_slow | input | 1 | Slow operation enable |
| ctl_div | input | 2 | Slow divider select, ratio 2^(d+1) |
| ctl_osc_ie | input | 1 | Oscillator interrupt enable; picks active-halt over halt |
| wfi_req | input | 1 | Wait-for-interrupt strobe from the core |
| halt_req | input | 1 | Halt strobe from the core |
| irq_any | input | 1 | Any pending interrupt |
| irq_rtc | input | 1 | Real-time-clock interrupt |
| irq_css | input | 1 | Clock-security interrupt |
| irq_halt_exit | input | 1 | Interrupt allowed to leave halt |
| wdg_active | input | 1 | Watchdog is running |
| opt_halt_rst | input | 1 | Halt with watchdog running causes reset |
| opt_long_start | input | 1 | Start-up delay 4096 instead of 256 cycles |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| cpu_tick | output | 1 | Divided clock-enable strobe |
| mode | output | 3 | 0 run, 1 slow, 2 wait, 3 slow-wait, 4 active-halt, 5 halt, 6 start-up |
| imask_load | output | 1 | Force interrupt mask this cycle |
| imask_val | output | 2 | Mask value to force |
| wdg_rst_req | output | 1 | Watchdog reset request pulse |
| wdg_freeze | output | 1 | Watchdog counting frozen |
| wdg_last_dec | output | 1 | Final watchdog decrement pulse |
| wake | output | 1 | CPU resumes this cycle |

## Verification
Every state change, clock enable and pulse is due on the cycle after the edge that samples the request or interrupt. The bench therefore queues each expectation tagged with the next cycle number, and the monitor compares it at the falling edge of that cycle. The halt start-up result is due 256 or 4096 cycles after the wake edge, and the bench counts falling edges from the start-up state until the CPU enable rises. Divider results are due only after a prescaler wrap, up to 16 cycles later. For that reason tick rates are measured after a settling gap, and the transition is judged only by the spacing between pulses.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_WAIT  = 3'd1,
    SQ_AHALT = 3'd2,
    SQ_HALT  = 3'd3,
    SQ_START = 3'd4
  } seq_e;

  localparam logic [2:0] MD_RUN   = 3'd0;
  localparam logic [2:0] MD_SLOW  = 3'd1;
  localparam logic [2:0] MD_WAIT  = 3'd2;
  localparam logic [2:0] MD_SWAIT = 3'd3;
  localparam logic [2:0] MD_AHALT = 3'd4;
  localparam logic [2:0] MD_HALT  = 3'd5;
  localparam logic [2:0] MD_START = 3'd6;

  localparam logic [1:0] IMASK_OPEN = 2'b10;
endpackage

// File: rtl/lpm_prescaler.sv
module lpm_prescaler #(
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slow_req,
  input  logic [DIV_SEL_W-1:0] div_req,
  output logic                 tick
);
  localparam int PRE_W = 1 << DIV_SEL_W;

  logic [PRE_W-1:0]     pre_q, pre_d;
  logic                 slow_q, slow_d;
  logic [DIV_SEL_W-1:0] div_q, div_d;
  logic [PRE_W-1:0]     mask;
  logic                 wrap;

  always_comb begin
    mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i <= int'(div_q)) mask[i] = 1'b1;
    end
  end

  assign wrap = &pre_q;
  assign tick = !slow_q || ((pre_q & mask) == mask);

  always_comb begin
    pre_d  = pre_q + PRE_W'(1);
    slow_d = slow_q;
    div_d  = div_q;
    if (wrap) begin
      slow_d = slow_req;
      div_d  = div_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      slow_q <= 1'b0;
      div_q  <= '0;
    end else begin
      pre_q  <= pre_d;
      slow_q <= slow_d;
      div_q  <= div_d;
    end
  end
endmodule

// File: rtl/lpm_wake_timer.sv
module lpm_wake_timer #(
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_sel,
  output logic done
);
  localparam int CW = $clog2(LONG_DLY);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = long_sel ? CW'(LONG_DLY - 1) : CW'(SHORT_DLY - 1);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CW'(1);
    end
  end

  assign done = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int DIV_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic                 ctl_slow,
  input  logic [DIV_SEL_W-1:0] ctl_div,
  input  logic                 ctl_osc_ie,
  input  logic                 wfi_req,
  input  logic                 halt_req,
  input  logic                 irq_any,
  input  logic                 irq_rtc,
  input  logic                 irq_css,
  input  logic                 irq_halt_exit,
  input  logic                 wdg_active,
  input  logic                 opt_halt_rst,
  input  logic                 tmr_done,
  output seq_e                 st_q,
  output logic                 slow_q,
  output logic [DIV_SEL_W-1:0] div_q,
  output logic                 tmr_load,
  output logic                 imask_q,
  output logic                 wrst_q,
  output logic                 freeze_q,
  output logic                 lastdec_q,
  output logic                 wake_q
);
  seq_e                 st_d;
  logic                 slow_d, osc_ie_q, osc_ie_d;
  logic [DIV_SEL_W-1:0] div_d;
  logic                 imask_d, wrst_d, freeze_d, lastdec_d, wake_d;

  always_comb begin
    st_d      = st_q;
    slow_d    = slow_q;
    div_d     = div_q;
    osc_ie_d  = osc_ie_q;
    imask_d   = 1'b0;
    wrst_d    = 1'b0;
    lastdec_d = 1'b0;
    wake_d    = 1'b0;
    freeze_d  = freeze_q;
    tmr_load  = 1'b0;
    if (ctl_wr) begin
      slow_d   = ctl_slow;
      div_d    = ctl_div;
      osc_ie_d = ctl_osc_ie;
    end
    case (st_q)
      SQ_RUN: begin
        if (halt_req) begin
          if (osc_ie_q) begin
            st_d    = SQ_AHALT;
            imask_d = 1'b1;
          end else if (wdg_active && opt_halt_rst) begin
            wrst_d = 1'b1;
          end else begin
            st_d    = SQ_HALT;
            imask_d = 1'b1;
            if (wdg_active) begin
              freeze_d  = 1'b1;
              lastdec_d = 1'b1;
            end
          end
        end else if (wfi_req) begin
          st_d    = SQ_WAIT;
          imask_d = 1'b1;
        end
      end
      SQ_WAIT: begin
        if (irq_any) begin
          st_d   = SQ_RUN;
          wake_d = 1'b1;
        end
      end
      SQ_AHALT: begin
        if (irq_rtc || irq_css || irq_halt_exit) begin
          st_d   = SQ_RUN;
          wake_d = 1'b1;
        end
      end
      SQ_HALT: begin
        if (irq_halt_exit) begin
          st_d     = SQ_START;
          tmr_load = 1'b1;
          freeze_d = 1'b0;
        end
      end
      default: begin
        if (tmr_done) begin
          st_d   = SQ_RUN;
          wake_d = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_RUN;
      slow_q    <= 1'b0;
      div_q     <= '0;
      osc_ie_q  <= 1'b0;
      imask_q   <= 1'b0;
      wrst_q    <= 1'b0;
      freeze_q  <= 1'b0;
      lastdec_q <= 1'b0;
      wake_q    <= 1'b0;
    end else begin
      st_q      <= st_d;
      slow_q    <= slow_d;
      div_q     <= div_d;
      osc_ie_q  <= osc_ie_d;
      imask_q   <= imask_d;
      wrst_q    <= wrst_d;
      freeze_q  <= freeze_d;
      lastdec_q <= lastdec_d;
      wake_q    <= wake_d;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DIV_SEL_W = 2,
  parameter int SHORT_DLY = 256,
  parameter int LONG_DLY  = 4096
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctl_wr,
  input  logic                 ctl_slow,
  input  logic [DIV_SEL_W-1:0] ctl_div,
  input  logic                 ctl_osc_ie,
  input  logic                 wfi_req,
  input  logic                 halt_req,
  input  logic                 irq_any,
  input  logic                 irq_rtc,
  input  logic                 irq_css,
  input  logic                 irq_halt_exit,
  input  logic                 wdg_active,
  input  logic                 opt_halt_rst,
  input  logic                 opt_long_start,
  output logic                 cpu_clk_en,
  output logic                 per_clk_en,
  output logic                 osc_en,
  output logic                 cpu_tick,
  output logic [2:0]           mode,
  output logic                 imask_load,
  output logic [1:0]           imask_val,
  output logic                 wdg_rst_req,
  output logic                 wdg_freeze,
  output logic                 wdg_last_dec,
  output logic                 wake
);
  logic [1:0]           rst_sync_q;
  logic                 rst_core_n;
  seq_e                 st;
  logic                 slow_cfg;
  logic [DIV_SEL_W-1:0] div_cfg;
  logic                 tmr_load, tmr_done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  lpm_sequencer #(.DIV_SEL_W(DIV_SEL_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .ctl_wr        (ctl_wr),
    .ctl_slow      (ctl_slow),
    .ctl_div       (ctl_div),
    .ctl_osc_ie    (ctl_osc_ie),
    .wfi_req       (wfi_req),
    .halt_req      (halt_req),
    .irq_any       (irq_any),
    .irq_rtc       (irq_rtc),
    .irq_css       (irq_css),
    .irq_halt_exit (irq_halt_exit),
    .wdg_active    (wdg_active),
    .opt_halt_rst  (opt_halt_rst),
    .tmr_done      (tmr_done),
    .st_q          (st),
    .slow_q        (slow_cfg),
    .div_q         (div_cfg),
    .tmr_load      (tmr_load),
    .imask_q       (imask_load),
    .wrst_q        (wdg_rst_req),
    .freeze_q      (wdg_freeze),
    .lastdec_q     (wdg_last_dec),
    .wake_q        (wake)
  );

  lpm_prescaler #(.DIV_SEL_W(DIV_SEL_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .slow_req (slow_cfg),
    .div_req  (div_cfg),
    .tick     (cpu_tick)
  );

  lpm_wake_timer #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (tmr_load),
    .long_sel (opt_long_start),
    .done     (tmr_done)
  );

  always_comb begin
    cpu_clk_en = (st == SQ_RUN);
    per_clk_en = (st == SQ_RUN) || (st == SQ_WAIT);
    osc_en     = (st != SQ_HALT);
    imask_val  = imask_load ? IMASK_OPEN : 2'b00;
    case (st)
      SQ_RUN:   mode = slow_cfg ? MD_SLOW : MD_RUN;
      SQ_WAIT:  mode = slow_cfg ? MD_SWAIT : MD_WAIT;
      SQ_AHALT: mode = MD_AHALT;
      SQ_HALT:  mode = MD_HALT;
      default:  mode = MD_START;
    endcase
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk
  import lpm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode,
  input logic       cpu_clk_en,
  input logic       osc_en,
  input logic       imask_load,
  input logic       wdg_rst_req,
  input logic       wdg_freeze,
  input logic       wake,
  input logic       wfi_req,
  input logic       halt_req,
  input logic       irq_any,
  input logic       irq_rtc,
  input logic       irq_css,
  input logic       irq_halt_exit,
  input logic       wdg_active,
  input logic       opt_halt_rst
);
  logic in_run, in_wait;
  assign in_run  = (mode == MD_RUN) || (mode == MD_SLOW);
  assign in_wait = (mode == MD_WAIT) || (mode == MD_SWAIT);

  AST_WFI_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && wfi_req && !halt_req) |=> in_wait); // R4
  AST_IMASK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    imask_load |-> !cpu_clk_en); // R4
  AST_HALT_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_HALT) |-> !osc_en); // R6
  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && irq_any) |=> (in_run && wake)); // R7
  AST_AHALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_AHALT) && !irq_rtc && !irq_css && !irq_halt_exit) |=> (mode == MD_AHALT)); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MD_HALT) && !irq_halt_exit) |=> (mode == MD_HALT)); // R9
  AST_START_NO_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_START) |-> (osc_en && !cpu_clk_en)); // R9
  AST_WRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_rst_req |-> (in_run && $past(halt_req && wdg_active && opt_halt_rst))); // R10
  AST_FREEZE_IN_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_freeze |-> (mode == MD_HALT)); // R11
endmodule

bind lpm_ctrl lpm_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .mode          (mode),
  .cpu_clk_en    (cpu_clk_en),
  .osc_en        (osc_en),
  .imask_load    (imask_load),
  .wdg_rst_req   (wdg_rst_req),
  .wdg_freeze    (wdg_freeze),
  .wake          (wake),
  .wfi_req       (wfi_req),
  .halt_req      (halt_req),
  .irq_any       (irq_any),
  .irq_rtc       (irq_rtc),
  .irq_css       (irq_css),
  .irq_halt_exit (irq_halt_exit),
  .wdg_active    (wdg_active),
  .opt_halt_rst  (opt_halt_rst)
);

// File: tb/lpm_ctrl_tb_top.sv
module lpm_ctrl_tb_top;
  import lpm_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, ctl_slow = 1'b0, ctl_osc_ie = 1'b0;
  logic [1:0] ctl_div = 2'b00;
  logic       wfi_req = 1'b0, halt_req = 1'b0;
  logic       irq_any = 1'b0, irq_rtc = 1'b0, irq_css = 1'b0, irq_halt_exit = 1'b0;
  logic       wdg_active = 1'b0, opt_halt_rst = 1'b0, opt_long_start = 1'b0;
  logic       cpu_clk_en, per_clk_en, osc_en, cpu_tick;
  logic [2:0] mode;
  logic       imask_load, wdg_rst_req, wdg_freeze, wdg_last_dec, wake;
  logic [1:0] imask_val;

  always #4 clk = ~clk;

  lpm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_slow(ctl_slow),
    .ctl_div(ctl_div), .ctl_osc_ie(ctl_osc_ie), .wfi_req(wfi_req),
    .halt_req(halt_req), .irq_any(irq_any), .irq_rtc(irq_rtc),
    .irq_css(irq_css), .irq_halt_exit(irq_halt_exit),
    .wdg_active(wdg_active), .opt_halt_rst(opt_halt_rst),
    .opt_long_start(opt_long_start), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .cpu_tick(cpu_tick),
    .mode(mode), .imask_load(imask_load), .imask_val(imask_val),
    .wdg_rst_req(wdg_rst_req), .wdg_freeze(wdg_freeze),
    .wdg_last_dec(wdg_last_dec), .wake(wake)
  );

  typedef struct {
    int          due;
    string       tag;
    logic [12:0] exp;
  } item_t;

  item_t sbq[$];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  logic [12:0] obs;
  assign obs = {mode, cpu_clk_en, per_clk_en, osc_en, imask_load, imask_val,
                wdg_rst_req, wdg_freeze, wdg_last_dec, wake};

  function automatic logic [12:0] mkv(input logic [2:0] md, input logic c,
      input logic p, input logic o, input logic im, input logic wr,
      input logic fz, input logic ld, input logic wk);
    return {md, c, p, o, im, (im ? 2'b10 : 2'b00), wr, fz, ld, wk};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare queued expectations on the cycle they fall due
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (obs !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%b expected=%b", it.tag, obs, it.exp);
      end
    end
  end

  task automatic step(input string tag, input logic [12:0] v);
    item_t it;
    it.due = cyc + 1;
    it.tag = tag;
    it.exp = v;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic s, input logic [1:0] d, input logic oie);
    ctl_wr = 1'b1; ctl_slow = s; ctl_div = d; ctl_osc_ie = oie;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic count_ticks(input int n, output int t);
    t = 0;
    repeat (n) begin
      if (cpu_tick) t++;
      @(negedge clk);
    end
  endtask

  task automatic wait_cpu(output int n);
    n = 0;
    while (!cpu_clk_en && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int t, n, last, bad, n16;
    idle(3);
    chk("R1 mode in reset", int'(mode), 0);
    chk("R1 enables in reset", int'({cpu_clk_en, per_clk_en, osc_en}), 7);
    rst_n = 1'b1;
    idle(5);
    chk("R1 state after release", int'(obs), int'(mkv(MD_RUN,1,1,1,0,0,0,0,0)));
    count_ticks(16, t);
    chk("R1 tick every cycle", t, 16);

    // R2: each divider ratio
    for (int d = 0; d < 4; d++) begin
      ctl_wr = 1'b1; ctl_slow = 1'b1; ctl_div = 2'(d); ctl_osc_ie = 1'b0;
      step("R2 slow mode code", mkv(MD_SLOW,1,1,1,0,0,0,0,0));
      ctl_wr = 1'b0;
      idle(20);
      count_ticks(64, t);
      chk($sformatf("R2 tick count div=%0d", d), t, 64 >> (d + 1));
    end

    // R3: change 2 -> 16 without runt pulses
    wr_ctl(1'b1, 2'd0, 1'b0);
    idle(20);
    wr_ctl(1'b1, 2'd3, 1'b0);
    last = -1; bad = 0; n16 = 0;
    for (int i = 0; i < 64; i++) begin
      if (cpu_tick) begin
        if (last >= 0) begin
          if (i - last == 16) n16++;
          else if (i - last != 2) bad++;
        end
        last = i;
      end
      @(negedge clk);
    end
    chk("R3 no runt gap", bad, 0);
    chk("R3 new ratio reached", int'(n16 >= 2), 1);

    // R4/R7: wait from run
    wr_ctl(1'b0, 2'd0, 1'b0);
    wfi_req = 1'b1;
    step("R4 wait entry", mkv(MD_WAIT,0,1,1,1,0,0,0,0));
    wfi_req = 1'b0;
    step("R4 wait hold", mkv(MD_WAIT,0,1,1,0,0,0,0,0));
    irq_any = 1'b1;
    step("R7 wait exit", mkv(MD_RUN,1,1,1,0,0,0,0,1));
    irq_any = 1'b0;
    step("R7 wake one cycle", mkv(MD_RUN,1,1,1,0,0,0,0,0));

    // R4/R7: slow-wait
    wr_ctl(1'b1, 2'd1, 1'b0);
    wfi_req = 1'b1;
    step("R4 slow-wait entry", mkv(MD_SWAIT,0,1,1,1,0,0,0,0));
    wfi_req = 1'b0;
    idle(3);
    irq_any = 1'b1;
    step("R7 slow-wait exit", mkv(MD_SLOW,1,1,1,0,0,0,0,1));
    irq_any = 1'b0;

    // R5/R8: active-halt
    wr_ctl(1'b0, 2'd0, 1'b1);
    halt_req = 1'b1;
    step("R5 active-halt entry", mkv(MD_AHALT,0,0,1,1,0,0,0,0));
    halt_req = 1'b0;
    irq_any = 1'b1;
    step("R8 any irq ignored", mkv(MD_AHALT,0,0,1,0,0,0,0,0));
    irq_any = 1'b0;
    step("R8 still active-halt", mkv(MD_AHALT,0,0,1,0,0,0,0,0));
    irq_rtc = 1'b1;
    step("R8 rtc exit", mkv(MD_RUN,1,1,1,0,0,0,0,1));
    irq_rtc = 1'b0;
    halt_req = 1'b1;
    step("R5 re-entry", mkv(MD_AHALT,0,0,1,1,0,0,0,0));
    halt_req = 1'b0;
    irq_css = 1'b1;
    step("R8 css exit", mkv(MD_RUN,1,1,1,0,0,0,0,1));
    irq_css = 1'b0;

    // R6/R9: full halt, short start-up
    wr_ctl(1'b0, 2'd0, 1'b0);
    halt_req = 1'b1;
    step("R6 halt entry", mkv(MD_HALT,0,0,0,1,0,0,0,0));
    halt_req = 1'b0;
    irq_any = 1'b1; irq_rtc = 1'b1;
    step("R9 halt ignores any/rtc", mkv(MD_HALT,0,0,0,0,0,0,0,0));
    irq_any = 1'b0; irq_rtc = 1'b0;
    irq_halt_exit = 1'b1; opt_long_start = 1'b0;
    step("R9 start-up state", mkv(MD_START,0,0,1,0,0,0,0,0));
    irq_halt_exit = 1'b0;
    wait_cpu(n);
    chk("R9 short start-up cycles", n, 256);
    chk("R9 wake at resume", int'(obs), int'(mkv(MD_RUN,1,1,1,0,0,0,0,1)));

    // R9: long start-up
    halt_req = 1'b1;
    step("R6 halt entry again", mkv(MD_HALT,0,0,0,1,0,0,0,0));
    halt_req = 1'b0;
    irq_halt_exit = 1'b1; opt_long_start = 1'b1;
    step("R9 start-up long", mkv(MD_START,0,0,1,0,0,0,0,0));
    irq_halt_exit = 1'b0; opt_long_start = 1'b0;
    wait_cpu(n);
    chk("R9 long start-up cycles", n, 4096);

    // R10: halt becomes watchdog reset
    wdg_active = 1'b1; opt_halt_rst = 1'b1;
    halt_req = 1'b1;
    step("R10 reset request", mkv(MD_RUN,1,1,1,0,1,0,0,0));
    halt_req = 1'b0;
    step("R10 pulse ends", mkv(MD_RUN,1,1,1,0,0,0,0,0));

    // R11: halt freezes watchdog after one decrement
    opt_halt_rst = 1'b0;
    halt_req = 1'b1;
    step("R11 halt with freeze", mkv(MD_HALT,0,0,0,1,0,1,1,0));
    halt_req = 1'b0;
    step("R11 frozen, one decrement", mkv(MD_HALT,0,0,0,0,0,1,0,0));
    irq_halt_exit = 1'b1;
    step("R11 freeze released", mkv(MD_START,0,0,1,0,0,0,0,0));
    irq_halt_exit = 1'b0;
    wait_cpu(n);
    chk("R11 resume after start-up", n, 256);

    // R12: active-halt with watchdog running
    wr_ctl(1'b0, 2'd0, 1'b1);
    opt_halt_rst = 1'b1;
    halt_req = 1'b1;
    step("R12 active-halt no reset", mkv(MD_AHALT,0,0,1,1,0,0,0,0));
    halt_req = 1'b0;
    step("R12 no freeze", mkv(MD_AHALT,0,0,1,0,0,0,0,0));
    irq_halt_exit = 1'b1;
    step("R12 exit", mkv(MD_RUN,1,1,1,0,0,0,0,1));
    irq_halt_exit = 1'b0;

    // R13: reset from frozen halt with slow settings
    opt_halt_rst = 1'b0;
    wr_ctl(1'b1, 2'd3, 1'b0);
    halt_req = 1'b1;
    step("R13 setup halt", mkv(MD_HALT,0,0,0,1,0,1,1,0));
    halt_req = 1'b0;
    wdg_active = 1'b0;
    idle(2);
    rst_n = 1'b0;
    #1;
    chk("R13 immediate reset", int'(obs), int'(mkv(MD_RUN,1,1,1,0,0,0,0,0)));
    @(negedge clk);
    rst_n = 1'b1;
    idle(5);
    chk("R13 settings cleared", int'(obs), int'(mkv(MD_RUN,1,1,1,0,0,0,0,0)));
    count_ticks(16, t);
    chk("R13 divider cleared", t, 16);

    idle(3);
    chk("scoreboard drained", sbq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule